// File: doc/BRIEF.md
# ADC Code Density Histogram Analyzer

This block is a built-in test engine for an analog-to-digital converter that is driven by a slow linear ramp. While it is idle, it counts how often each output code appears on a sample bus. When it is told to analyze, it first adds up the counts of every code except the lowest and the highest. Those two end codes are left out because the ramp deliberately overdrives both ends of the input range. The engine then streams one result per inner code. Each result holds the code, its count, the differential nonlinearity (DNL), the integral nonlinearity (INL) and a flag for a code that never occurred.

DNL is computed without forming the average first. The count is scaled by the number of inner codes and by 2^FRAC_W, then divided by the inner sum in a bit-serial divider. One LSB of the ideal step width is subtracted from the quotient. INL is the running total of the DNL values already emitted.

The controller is a single state machine with these states:
- S_IDLE: collect samples, accept clear and start.
- S_SUM: add the inner bins, one per cycle.
- S_CHK: test the sum for zero.
- S_DIV: launch the divider.
- S_WAIT: wait for the quotient.
- S_OUT: present a result and wait for ready.
- S_DONE: one-cycle completion pulse.

The state transitions are:
- S_IDLE→S_SUM on start.
- S_SUM→S_CHK after the last inner bin.
- S_CHK→S_DIV when the sum is nonzero, and S_CHK→S_OUT when it is zero.
- S_DIV→S_WAIT.
- S_WAIT→S_OUT when the divider finishes.
- S_OUT→S_DIV, S_OUT→S_OUT (zero-sum case) or S_OUT→S_DONE on an accepted result.
- S_DONE→S_IDLE.

Top module: `adc_hist_analyzer`

## Requirements
- R1: In S_IDLE, with clr low, each cycle with smp_valid high adds one to the bin of smp_code.
- R2: A bin holds at 2^CNT_W-1 instead of wrapping. A sample that arrives for a bin already at that value sets overflow, which stays high until clr or reset.
- R3: clr in S_IDLE zeroes every bin and drops overflow. If clr and start are both high, clr wins and start is ignored.
- R4: While busy is high (any state other than S_IDLE), samples are ignored and leave every bin unchanged.
- R5: After start, results appear for codes 1 to 2^CODE_W-2 only, in ascending order. res_count is the bin count. Codes 0 and 2^CODE_W-1 contribute to neither the sum nor the results.
- R6: res_dnl is two's complement with FRAC_W fractional bits. It equals floor(count*(2^CODE_W-2)*2^FRAC_W / S) - 2^FRAC_W, where S is the sum of the inner bins.
- R7: res_missing is high exactly when the count is zero. Such a code reports res_dnl = -2^FRAC_W (that is, -1 LSB).
- R8: res_inl of code m is the sum of res_dnl over codes 1 to m-1, so code 1 reports 0.
- R9: A result is transferred on a cycle where res_valid and res_ready are both high. While res_ready is low, all result fields hold.
- R10: done is high for exactly one cycle, the cycle after the transfer of the last inner code.
- R11: If S is zero, no division is made. zero_err is set, and every result reports res_dnl = 0 and res_inl = 0. zero_err clears on the next start.
- R12: After reset, busy, res_valid, done, overflow and zero_err are low and all bins are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | CODE_W | Converter output code |
| clr | input | 1 | Zero all bins (idle only) |
| start | input | 1 | Begin analysis (idle only) |
| res_ready | input | 1 | Consumer accepts result |
| res_valid | output | 1 | Result present |
| res_code | output | CODE_W | Code of the result |
| res_count | output | CNT_W | Bin count |
| res_dnl | output | 2*CODE_W+FRAC_W+2 | DNL, signed, FRAC_W fraction bits |
| res_inl | output | 2*CODE_W+FRAC_W+2 | INL, signed, FRAC_W fraction bits |
| res_missing | output | 1 | Count is zero |
| done | output | 1 | One-cycle end pulse |
| busy | output | 1 | Not in S_IDLE |
| overflow | output | 1 | Sticky saturation flag |
| zero_err | output | 1 | Inner sum was zero |

## Verification
The bench builds the block with CODE_W=3, CNT_W=8 and FRAC_W=8. This gives six inner codes, a sum small enough for the bench to recompute every quotient exactly, and a bin ceiling of 255 that a few hundred samples reach, so saturation and the overflow flag are exercised. The same small code space lets a directed pattern with a missing code, random sample streams, and a run with only end-bin hits all complete in a few thousand cycles under random ready backpressure.

// File: rtl/adc_hist_pkg.sv
package adc_hist_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SUM,
        S_CHK,
        S_DIV,
        S_WAIT,
        S_OUT,
        S_DONE
    } ana_state_t;

endpackage

// File: rtl/adc_hist_bins.sv
module adc_hist_bins #(
    parameter int CODE_W = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc_en,
    input  logic [CODE_W-1:0] inc_idx,
    input  logic [CODE_W-1:0] rd_idx,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic              sat_hit
);
    localparam int BINS = 1 << CODE_W;

    logic [CNT_W-1:0] cnt_q [BINS];

    for (genvar g = 0; g < BINS; g++) begin : g_bin
        logic hit;
        assign hit = inc_en && (inc_idx == CODE_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (clr) begin
                cnt_q[g] <= '0;
            end else if (hit && (cnt_q[g] != '1)) begin
                cnt_q[g] <= cnt_q[g] + 1'b1;
            end
        end

        // R1
        bin_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> cnt_q[g] >= $past(cnt_q[g]));
        // R2
        bin_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[g] == '1 && !clr) |=> cnt_q[g] == '1);
    end

    assign rd_cnt  = cnt_q[rd_idx];
    assign sat_hit = inc_en && (cnt_q[inc_idx] == '1);

endmodule

// File: rtl/adc_hist_div.sv
module adc_hist_div #(
    parameter int NUM_W = 19,
    parameter int DEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             fin,
    output logic [NUM_W-1:0] quo
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0]  rem_q;
    logic [NUM_W-1:0]  quo_q;
    logic [STEP_W-1:0] step_q;
    logic              run_q;
    logic              fin_q;
    logic [DEN_W:0]    trial;

    assign trial = {rem_q, quo_q[NUM_W-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            step_q <= '0;
            run_q  <= 1'b0;
            fin_q  <= 1'b0;
        end else if (go) begin
            rem_q  <= '0;
            quo_q  <= num;
            step_q <= STEP_W'(NUM_W);
            run_q  <= 1'b1;
            fin_q  <= 1'b0;
        end else if (run_q) begin
            if (trial >= {1'b0, den}) begin
                rem_q <= DEN_W'(trial - {1'b0, den});
                quo_q <= {quo_q[NUM_W-2:0], 1'b1};
            end else begin
                rem_q <= trial[DEN_W-1:0];
                quo_q <= {quo_q[NUM_W-2:0], 1'b0};
            end
            step_q <= step_q - 1'b1;
            if (step_q == STEP_W'(1)) begin
                run_q <= 1'b0;
                fin_q <= 1'b1;
            end
        end else begin
            fin_q <= 1'b0;
        end
    end

    assign fin = fin_q;
    assign quo = quo_q;

    // R6
    div_fin_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |=> !fin_q);

endmodule

// File: rtl/adc_hist_analyzer.sv
module adc_hist_analyzer
    import adc_hist_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int CNT_W  = 16,
    parameter int FRAC_W = 8,
    parameter int OUT_W  = 2 * CODE_W + FRAC_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [CODE_W-1:0]       smp_code,
    input  logic                    clr,
    input  logic                    start,
    input  logic                    res_ready,
    output logic                    res_valid,
    output logic [CODE_W-1:0]       res_code,
    output logic [CNT_W-1:0]        res_count,
    output logic signed [OUT_W-1:0] res_dnl,
    output logic signed [OUT_W-1:0] res_inl,
    output logic                    res_missing,
    output logic                    done,
    output logic                    busy,
    output logic                    overflow,
    output logic                    zero_err
);
    localparam int INNER  = (1 << CODE_W) - 2;
    localparam int SUM_W  = CNT_W + CODE_W;
    localparam int DIVD_W = CNT_W + CODE_W + FRAC_W;
    localparam logic [CODE_W-1:0] FIRST = CODE_W'(1);
    localparam logic [CODE_W-1:0] LAST  = CODE_W'(INNER);
    localparam logic [OUT_W-1:0]  ONE_V = OUT_W'(1) << FRAC_W;
    localparam logic [OUT_W-1:0]  NEG1  = ~ONE_V + OUT_W'(1);

    ana_state_t state_q, state_d;

    logic [CODE_W-1:0] idx_q;
    logic [SUM_W-1:0]  sum_q;
    logic [OUT_W-1:0]  dnl_q;
    logic [OUT_W-1:0]  inl_q;
    logic              zero_q;
    logic              ovf_q;

    logic              idle;
    logic              bin_clr;
    logic              inc_en;
    logic              sat_hit;
    logic [CNT_W-1:0]  rd_cnt;
    logic              div_go;
    logic              div_fin;
    logic [DIVD_W-1:0] div_num;
    logic [DIVD_W-1:0] div_quo;
    logic              xfer;

    assign idle    = (state_q == S_IDLE);
    assign bin_clr = idle && clr;
    assign inc_en  = idle && !clr && smp_valid;
    assign xfer    = (state_q == S_OUT) && res_ready;
    assign div_num = (DIVD_W'(rd_cnt) * DIVD_W'(INNER)) << FRAC_W;

    adc_hist_bins #(
        .CODE_W(CODE_W),
        .CNT_W (CNT_W)
    ) bins_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (bin_clr),
        .inc_en (inc_en),
        .inc_idx(smp_code),
        .rd_idx (idx_q),
        .rd_cnt (rd_cnt),
        .sat_hit(sat_hit)
    );

    adc_hist_div #(
        .NUM_W(DIVD_W),
        .DEN_W(SUM_W)
    ) div_i (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (div_num),
        .den  (sum_q),
        .fin  (div_fin),
        .quo  (div_quo)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start && !clr) state_d = S_SUM;
            S_SUM:  if (idx_q == LAST) state_d = S_CHK;
            S_CHK:  state_d = (sum_q == '0) ? S_OUT : S_DIV;
            S_DIV:  state_d = S_WAIT;
            S_WAIT: if (div_fin) state_d = S_OUT;
            S_OUT: begin
                if (res_ready) begin
                    if (idx_q == LAST) state_d = S_DONE;
                    else if (zero_q)   state_d = S_OUT;
                    else               state_d = S_DIV;
                end
            end
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            sum_q  <= '0;
            dnl_q  <= '0;
            inl_q  <= '0;
            zero_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (bin_clr) begin
                ovf_q <= 1'b0;
            end else if (sat_hit) begin
                ovf_q <= 1'b1;
            end
            unique case (state_q)
                S_IDLE: begin
                    if (start && !clr) begin
                        idx_q  <= FIRST;
                        sum_q  <= '0;
                        inl_q  <= '0;
                        zero_q <= 1'b0;
                    end
                end
                S_SUM: begin
                    sum_q <= sum_q + SUM_W'(rd_cnt);
                    idx_q <= (idx_q == LAST) ? FIRST : idx_q + 1'b1;
                end
                S_CHK: begin
                    if (sum_q == '0) begin
                        zero_q <= 1'b1;
                        dnl_q  <= '0;
                    end
                end
                S_DIV: ;
                S_WAIT: begin
                    if (div_fin) begin
                        dnl_q <= OUT_W'(div_quo) - ONE_V;
                    end
                end
                S_OUT: begin
                    if (res_ready) begin
                        inl_q <= inl_q + dnl_q;
                        if (idx_q != LAST) idx_q <= idx_q + 1'b1;
                    end
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        res_valid = 1'b0;
        done      = 1'b0;
        div_go    = 1'b0;
        unique case (state_q)
            S_IDLE, S_SUM, S_CHK, S_WAIT: ;
            S_DIV:  div_go    = 1'b1;
            S_OUT:  res_valid = 1'b1;
            S_DONE: done      = 1'b1;
            default: ;
        endcase
    end

    assign busy        = !idle;
    assign res_code    = idx_q;
    assign res_count   = rd_cnt;
    assign res_dnl     = dnl_q;
    assign res_inl     = inl_q;
    assign res_missing = (rd_cnt == '0);
    assign overflow    = ovf_q;
    assign zero_err    = zero_q;

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_code)
            && $stable(res_dnl) && $stable(res_inl) && $stable(res_count)));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(xfer && res_code == LAST));
    // R7
    missing_dnl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_missing && !zero_err) |-> res_dnl == NEG1);
    // R11
    zero_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && zero_err) |-> (res_dnl == '0 && res_inl == '0));
    // R8
    first_inl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code == FIRST) |-> res_inl == '0);
    // R5
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_code >= FIRST && res_code <= LAST));
    // R2
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !bin_clr) |=> overflow);

endmodule

// File: tb/adc_hist_analyzer_tb_top.sv
module adc_hist_analyzer_tb_top;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 8;
    localparam int FRAC_W = 8;
    localparam int OUT_W  = 2 * CODE_W + FRAC_W + 2;
    localparam int BINS   = 1 << CODE_W;
    localparam int INNER  = BINS - 2;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [CODE_W-1:0] smp_code = '0;
    logic clr = 1'b0;
    logic start = 1'b0;
    logic res_ready = 1'b0;
    logic res_valid;
    logic [CODE_W-1:0] res_code;
    logic [CNT_W-1:0] res_count;
    logic signed [OUT_W-1:0] res_dnl;
    logic signed [OUT_W-1:0] res_inl;
    logic res_missing, done, busy, overflow, zero_err;

    int checks = 0;
    int fails  = 0;
    int model [BINS];

    always #2.5ns clk = ~clk;

    adc_hist_analyzer #(
        .CODE_W(CODE_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .clr(clr), .start(start), .res_ready(res_ready), .res_valid(res_valid),
        .res_code(res_code), .res_count(res_count), .res_dnl(res_dnl),
        .res_inl(res_inl), .res_missing(res_missing), .done(done), .busy(busy),
        .overflow(overflow), .zero_err(zero_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint exp_dnl(input int cnt, input longint sum);
        if (sum == 0) return 0;
        return (longint'(cnt) * INNER * (1 << FRAC_W)) / sum - (1 << FRAC_W);
    endfunction

    task automatic put(input int code, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_code  = CODE_W'(code);
            if (model[code] < CMAX) model[code]++;
        end
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        for (int b = 0; b < BINS; b++) model[b] = 0;
    endtask

    task automatic analyze(input bit noisy, input bit bp);
        longint sum = 0;
        longint inl = 0;
        int k = 1;
        bit fin = 0;
        for (int b = 1; b <= INNER; b++) sum += model[b];
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 20000 && !fin; cyc++) begin
            @(negedge clk);
            if (noisy) begin
                smp_valid = 1'b1;
                smp_code  = CODE_W'($urandom % BINS);
            end
            // R10: no early done
            if (done) chk(0, "R10 early done", 1, 0);
            res_ready = 1'b0;
            if (res_valid) begin
                res_ready = bp ? (($urandom % 3) != 0) : 1'b1;
                if (res_ready) begin
                    longint d = exp_dnl(model[k], sum);
                    chk(res_code == CODE_W'(k), "R5 code order", res_code, k);
                    chk(res_count == CNT_W'(model[k]), "R5 count", res_count, model[k]);
                    chk(longint'(res_dnl) == d, "R6 dnl", res_dnl, d);
                    chk(longint'(res_inl) == inl, "R8 inl", res_inl, inl);
                    chk(res_missing == (model[k] == 0), "R7 missing", res_missing, model[k] == 0);
                    chk(zero_err == (sum == 0), "R11 zero_err", zero_err, sum == 0);
                    inl += d;
                    k++;
                    if (k > INNER) fin = 1;
                end
            end
        end
        @(negedge clk);
        res_ready = 1'b0;
        smp_valid = 1'b0;
        chk(fin, "R5 all results", k - 1, INNER);
        chk(done == 1'b1, "R10 done pulse", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", done, 0);
        chk(busy == 1'b0, "R10 back to idle", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        for (int b = 0; b < BINS; b++) model[b] = 0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!busy && !res_valid && !done, "R12 idle outputs", {busy, res_valid, done}, 0);
        chk(!overflow && !zero_err, "R12 flags", {overflow, zero_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        analyze(0, 0); // R12 all bins zero -> zero sum path

        // Directed pattern with a missing code and overdriven end bins (R1 R5 R6 R7 R8)
        put(0, 40);
        put(1, 125); put(2, 150); put(3, 125); put(4, 75); put(6, 125);
        put(7, 90);
        analyze(0, 1);

        // R3 clear with start in the same cycle: start ignored
        @(negedge clk);
        clr = 1'b1; start = 1'b1;
        @(negedge clk);
        clr = 1'b0; start = 1'b0;
        for (int b = 0; b < BINS; b++) model[b] = 0;
        chk(busy == 1'b0, "R3 start ignored with clr", busy, 0);
        put(5, 3);
        analyze(0, 0); // R3 other bins zero after clear

        // Random streams, with samples driven during analysis (R4)
        for (int r = 0; r < 4; r++) begin
            do_clear();
            for (int i = 0; i < 150 + int'($urandom % 150); i++) put($urandom % BINS, 1);
            analyze(1, 1);
            analyze(0, 1); // R4 counts unchanged by samples seen while busy
        end

        // R11 only end bins hit
        do_clear();
        put(0, 20); put(BINS - 1, 20);
        analyze(0, 1);

        // R2 saturation and sticky overflow
        do_clear();
        put(3, CMAX);
        chk(overflow == 1'b0, "R2 no overflow at ceiling", overflow, 0);
        put(3, 45);
        put(2, 10);
        chk(overflow == 1'b1, "R2 overflow sticky", overflow, 1);
        analyze(0, 0);
        do_clear();
        chk(overflow == 1'b0, "R3 clear drops overflow", overflow, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule